// File: doc/BRIEF.md
# Three-wire serial EEPROM burst read master

This block reads a run of words from a three-wire serial EEPROM (separate chip select, serial clock, data-in and data-out lines). A local host gives a start pulse with a word address and a word count. The block raises chip select and sends a command frame: a start bit, the two-bit read op-code and the address. It then gathers the memory's reply into words and hands each finished word to the host with a one-cycle valid strobe.

The memory answers a read with one zero bit before the first data word. That bit falls in the clock period right after the last address bit. A capture that groups bits from the end of the command would be off by one bit. This block counts the command bits, drops exactly that one bit, and assembles the rest MSB first. While chip select stays high the memory steps its own address and streams the next word with no gap bit, so the skip happens only once per burst. After the requested number of words the block lowers chip select and stays busy for a short hold time before it accepts new work.

Word size is a parameter. 16-bit words use an 8-bit address and 8-bit words use a 9-bit address, for a 4 Kbit array. The serial clock runs at the system clock divided by 2·DIV.

Top module: `mw_read_master`

## Requirements
- R1: After reset, chip select, serial clock, busy and word valid are all low.
- R2: A start with a non-zero count raises chip select and busy at once. The block then sends the frame 1, 1, 0 followed by the address MSB first, one bit per serial clock rising edge. The data-in line never changes while the serial clock is high.
- R3: The serial clock idles low whenever chip select is low. While running, its period is 2·DIV system clocks (40 ns with DIV = 4 at 200 MHz).
- R4: The single bit sampled in the clock period after the last address bit is discarded. The first word is built from the next WORD_W sampled bits, MSB first.
- R5: Later words in the same burst follow with no skipped bit, and they come from consecutive addresses that wrap modulo 2^ADDR_W.
- R6: Each word appears on the data output with a one-cycle valid pulse. A burst gives exactly the requested count of pulses.
- R7: Reply bits are sampled at the serial clock falling edge, half a period after the memory changes its output on the rising edge.
- R8: Chip select falls together with the final falling edge of the last word, in the same cycle as that word's valid pulse. No serial clock edges occur after that.
- R9: Busy stays high from the accepted start until DIV system clocks after chip select falls.
- R10: A start with count 0 is ignored (chip select and busy stay low). A start while busy is ignored, so the running burst keeps its address and count.
- R11: With WORD_W = 16 the address field is 8 bits, giving an 11-bit command frame. With WORD_W = 8 it is 9 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a burst read (one-cycle pulse) |
| addr_i | input | ADDR_W | First word address |
| count_i | input | CNT_W | Number of words to read |
| busy_o | output | 1 | Transfer in progress |
| word_valid_o | output | 1 | One-cycle strobe for a finished word |
| word_data_o | output | WORD_W | Received word |
| cs_o | output | 1 | Memory chip select, active high |
| sclk_o | output | 1 | Serial clock to the memory |
| mosi_o | output | 1 | Serial data to the memory |
| miso_i | input | 1 | Serial data from the memory |

## Verification
The bench's memory responder drives a zero dummy bit after the address and then data words whose MSB is often 1. A design that does not skip the dummy bit, or that skips it again between words, returns every word shifted by one bit. That shift shows up as a data mismatch. The responder changes its output just after each rising edge, so a design that samples on the rising edge instead reads the previous bit. A burst that starts near the top address checks address wrap. A start pulse during a burst checks that a design which reloads its address or count is caught by an extra word or by wrong addresses. The end-of-burst checks catch a chip select that drops a cycle late, and a busy flag that clears early or late.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } mw_state_e;

  localparam int HDR_BITS = 3;

  function automatic int addr_width(input int word_w);
    return (word_w == 8) ? 9 : 8;
  endfunction

  function automatic int frame_len(input int addr_w);
    return HDR_BITS + addr_w;
  endfunction

  function automatic logic [31:0] cmd_frame(input logic [15:0] addr, input int addr_w);
    logic [31:0] hdr;
    logic [31:0] body;
    hdr  = 32'd6 << addr_w;
    body = 32'(addr) & ((32'd1 << addr_w) - 32'd1);
    return hdr | body;
  endfunction

endpackage

// File: rtl/mw_sclk_gen.sv
module mw_sclk_gen #(
  parameter int DIV = 4,
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  logic [TW-1:0] half_cnt;
  logic          half_end;

  assign half_end = run_i && (half_cnt == TW'(DIV - 1));
  assign rise_o   = half_end && !sclk_o;
  assign fall_o   = half_end && sclk_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      sclk_o   <= 1'b0;
    end else if (!run_i) begin
      half_cnt <= '0;
      sclk_o   <= 1'b0;
    end else if (half_end) begin
      half_cnt <= '0;
      sclk_o   <= ~sclk_o;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sclk_o);

endmodule

// File: rtl/mw_tx_frame.sv
module mw_tx_frame #(
  parameter int ADDR_W = 8,
  localparam int FLEN = mw_pkg::frame_len(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  input  logic              sclk_i,
  output logic              mosi_o
);

  logic [FLEN-1:0] frame_sr;
  logic [31:0]     frame_full;

  assign frame_full = mw_pkg::cmd_frame(16'(addr_i), ADDR_W);
  assign mosi_o     = frame_sr[FLEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_sr <= '0;
    end else if (load_i) begin
      frame_sr <= frame_full[FLEN-1:0];
    end else if (shift_i) begin
      frame_sr <= {frame_sr[FLEN-2:0], 1'b0};
    end
  end

  p_mosi_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_i |-> $stable(mosi_o));

endmodule

// File: rtl/mw_rx_deser.sv
module mw_rx_deser #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8,
  localparam int FLEN = mw_pkg::frame_len(ADDR_W),
  localparam int HW   = $clog2(FLEN + 1),
  localparam int BW   = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              fall_i,
  input  logic              sclk_i,
  input  logic              miso_i,
  output logic              word_end_o,
  output logic              dummy_slot_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);

  logic [HW-1:0]     hdr_cnt;
  logic [BW-1:0]     bit_pos;
  logic [WORD_W-1:0] data_sr;
  logic              in_data;
  logic              take_bit;

  assign in_data      = (hdr_cnt == HW'(FLEN));
  assign dummy_slot_o = fall_i && (hdr_cnt == HW'(FLEN - 1));
  assign take_bit     = fall_i && in_data;
  assign word_end_o   = take_bit && (bit_pos == BW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_cnt <= '0;
      bit_pos <= '0;
      data_sr <= '0;
    end else if (clear_i) begin
      hdr_cnt <= '0;
      bit_pos <= '0;
      data_sr <= '0;
    end else if (fall_i && !in_data) begin
      hdr_cnt <= hdr_cnt + 1'b1;
    end else if (take_bit) begin
      data_sr <= {data_sr[WORD_W-2:0], miso_i};
      bit_pos <= word_end_o ? '0 : bit_pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      word_valid_o <= word_end_o;
      if (word_end_o) word_o <= {data_sr[WORD_W-2:0], miso_i};
    end
  end

  p_sample_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_bit |-> sclk_i);
  p_dummy_then_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_slot_o && !clear_i) |=> in_data && (bit_pos == '0));
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

endmodule

// File: rtl/mw_read_master.sv
module mw_read_master #(
  parameter int WORD_W = 16,
  parameter int DIV    = 4,
  parameter int CNT_W  = 9,
  localparam int ADDR_W = mw_pkg::addr_width(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);

  import mw_pkg::*;

  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

  mw_state_e        state;
  logic [TW-1:0]    gap_cnt;
  logic [CNT_W-1:0] words_left;
  logic             accept;
  logic             run_clk;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             word_end;
  logic             dummy_slot;
  logic             gap_done;
  logic             last_word;

  assign accept    = (state == ST_IDLE) && start_i && (count_i != '0);
  assign run_clk   = (state == ST_RUN);
  assign gap_done  = (gap_cnt == TW'(DIV - 1));
  assign last_word = word_end && (words_left == CNT_W'(1));

  mw_sclk_gen #(.DIV(DIV)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_clk),
    .sclk_o (sclk_o),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  mw_tx_frame #(.ADDR_W(ADDR_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .addr_i  (addr_i),
    .shift_i (sclk_fall),
    .sclk_i  (sclk_o),
    .mosi_o  (mosi_o)
  );

  mw_rx_deser #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (accept),
    .fall_i       (sclk_fall),
    .sclk_i       (sclk_o),
    .miso_i       (miso_i),
    .word_end_o   (word_end),
    .dummy_slot_o (dummy_slot),
    .word_valid_o (word_valid_o),
    .word_o       (word_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      gap_cnt    <= '0;
      words_left <= '0;
      cs_o       <= 1'b0;
      busy_o     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_SETUP;
            gap_cnt    <= '0;
            words_left <= count_i;
            cs_o       <= 1'b1;
            busy_o     <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (gap_done) begin
            state   <= ST_RUN;
            gap_cnt <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (word_end) words_left <= words_left - 1'b1;
          if (last_word) begin
            state   <= ST_HOLD;
            gap_cnt <= '0;
            cs_o    <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (gap_done) begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_cs_low_sclk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_o |-> !sclk_o);
  p_cs_drop_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_o) |-> !sclk_o && word_valid_o);
  p_busy_covers_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o |-> busy_o);
  p_valid_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(cs_o));
  p_dummy_under_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_slot |-> cs_o && sclk_o);
  p_start_busy_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !word_end) |=> $stable(words_left));

endmodule

// File: tb/sim_mw_read_master.sv
`timescale 1ns/1ps
module sim_mw_read_master;

  localparam int WORD_W = 16;
  localparam int DIV    = 4;
  localparam int CNT_W  = 9;
  localparam int AW     = (WORD_W == 8) ? 9 : 8;
  localparam int FL     = AW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic busy_o, word_valid_o, cs_o, sclk_o, mosi_o;
  logic [WORD_W-1:0] word_data_o;
  logic miso_i = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  mw_read_master #(.WORD_W(WORD_W), .DIV(DIV), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .count_i(count_i),
    .busy_o(busy_o), .word_valid_o(word_valid_o), .word_data_o(word_data_o),
    .cs_o(cs_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i));

  function automatic logic [WORD_W-1:0] mem_word(input logic [AW-1:0] a);
    logic [31:0] t;
    t = (32'(a) * 32'h9E37) ^ 32'hC3A5;
    return t[WORD_W-1:0];
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder
  int rcnt = 0;
  int bidx = 0;
  logic [FL-1:0] cmd_in = '0;
  logic [AW-1:0] mptr = '0;
  always @(posedge sclk_o) begin
    if (cs_o) begin
      rcnt++;
      if (rcnt <= FL) cmd_in = {cmd_in[FL-2:0], mosi_o};
      #1;
      if (rcnt == FL) begin
        miso_i = 1'b0;
        mptr = cmd_in[AW-1:0];
        bidx = 0;
      end else if (rcnt > FL) begin
        miso_i = mem_word(mptr)[WORD_W-1-bidx];
        bidx++;
        if (bidx == WORD_W) begin
          bidx = 0;
          mptr = mptr + 1'b1;
        end
      end
    end
  end
  always @(negedge cs_o) begin
    rcnt = 0;
    miso_i = 1'b1;
  end

  // monitors
  logic [WORD_W-1:0] rx_buf [64];
  int rx_n = 0;
  int mosi_bad = 0;
  int idle_bad = 0;
  realtime last_rise = 0.0;
  realtime sclk_per = 0.0;
  logic mosi_prev = 1'b0;
  always @(posedge clk) begin
    #1;
    if (word_valid_o && rx_n < 64) begin
      rx_buf[rx_n] = word_data_o;
      rx_n++;
    end
    if (sclk_o && mosi_o != mosi_prev) mosi_bad++;
    if (!cs_o && sclk_o) idle_bad++;
    mosi_prev = mosi_o;
  end
  always @(posedge sclk_o) begin
    if (last_rise != 0.0) sclk_per = $realtime - last_rise;
    last_rise = $realtime;
  end
  always @(negedge cs_o) last_rise = 0.0;

  task automatic do_read(input logic [AW-1:0] a, input int n, input string name, input bit poke);
    int guard;
    int k;
    rx_n = 0;
    @(negedge clk);
    start_i = 1'b1; addr_i = a; count_i = CNT_W'(n);
    @(negedge clk);
    start_i = 1'b0;
    check("R2", {name, " cs raised"}, cs_o, 1);
    check("R9", {name, " busy raised"}, busy_o, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1; addr_i = a + 8'd17; count_i = CNT_W'(n + 3);
      @(negedge clk);
      start_i = 1'b0; addr_i = '0;
    end
    guard = 0;
    while (rx_n < n && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check("R6", {name, " words arrived"}, rx_n, n);
    check("R8", {name, " cs low with last word"}, cs_o, 0);
    check("R3", {name, " sclk period ns"}, longint'(sclk_per), 2 * DIV * 5);
    k = 0;
    while (busy_o && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check("R9", {name, " busy hold cycles"}, k, DIV);
    check("R2", {name, " frame"}, cmd_in, {3'b110, a});
    check("R11", {name, " frame length"}, FL, 11);
    for (int i = 0; i < n; i++)
      check(i == 0 ? "R4 R7" : "R5", {name, " word"}, rx_buf[i], mem_word(a + AW'(i)));
    repeat (4 * DIV * 3) @(negedge clk);
    check("R6", {name, " no extra words"}, rx_n, n);
    check("R10", {name, " idle after burst"}, busy_o, 0);
  endtask

  task automatic t_reset();
    check("R1", "cs at reset", cs_o, 0);
    check("R1", "sclk at reset", sclk_o, 0);
    check("R1", "busy at reset", busy_o, 0);
    check("R1", "valid at reset", word_valid_o, 0);
  endtask

  task automatic t_zero_count();
    @(negedge clk);
    start_i = 1'b1; addr_i = 8'h33; count_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    check("R10", "zero count busy", busy_o, 0);
    check("R10", "zero count cs", cs_o, 0);
    check("R10", "zero count words", rx_n, 0);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rx_n = 0;
        t_zero_count();
        do_read(8'h00, 1, "single", 1'b0);
        do_read(8'h05, 4, "burst", 1'b0);
        do_read(8'hFE, 4, "wrap", 1'b0);
        do_read(8'h80, 3, "poke", 1'b1);
        check("R2", "mosi moved while sclk high", mosi_bad, 0);
        check("R3", "sclk high with cs low", idle_bad, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule